// File: doc/BRIEF.md
# Multi-Polynomial Streaming CRC Unit

This block keeps a running cyclic redundancy checksum over a stream of data words of any length. Software picks one of four fixed generator polynomials through a two-bit select, loads a seed, and then offers words on a valid/ready write port. Every accepted word is folded into the running value in one clock cycle, most significant bit first, with no reflection and no final inversion. The running value is always visible on `crc_out`.

For checking a received stream, the expected checksum is presented together with a one-cycle compare request. One cycle later the unit reports whether the running value matched, and a sticky mismatch flag records any failed compare until the checksum is reinitialised. Several copies can be placed side by side; each is fully independent.

Top module: `crc_stream_unit`

## Requirements
- R1: `poly_sel` encodes the mode: 0 = 32-bit polynomial 0x04C11DB7, 1 = 16-bit polynomial 0x1021, 2 = 8-bit polynomial 0x1D, 3 = 8-bit polynomial 0x2F; each accepted word is folded MSB first (per bit: feedback = top CRC bit XOR data bit, shift left, XOR polynomial on feedback) and the new value is on `crc_out` after the accepting clock edge.
- R2: A cycle with `seed_we` high stores `seed_val`, loads the running value with `seed_val` masked to the width of the mode on `poly_sel`, and clears the mismatch flag.
- R3: When `poly_sel` differs from the mode in use, the next edge switches to the new mode and reloads the running value with the stored seed masked to the new width, clearing the mismatch flag.
- R4: In the 16-bit mode `crc_out[31:16]` reads zero; in both 8-bit modes `crc_out[31:8]` reads zero.
- R5: `in_ready` is low in any cycle with `seed_we` high or a pending mode change; a word offered then is dropped and does not affect the result.
- R6: With no accepted word and no reinitialisation, `crc_out` holds its value.
- R7: A `chk_go` pulse compares the value on `crc_out` in that cycle with `chk_expect` masked to the mode width; after the next edge `chk_done` is high for exactly one cycle and `chk_match` gives the outcome.
- R8: A failed compare sets `chk_mismatch`, which stays set across later compares, matching or not, until R2 or R3 reinitialises.
- R9: After reset `crc_out` is zero, the mode is 0, the stored seed is zero and all check flags are low.
- R10: There is no stream length limit: any number of words keeps accumulating into the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| poly_sel | input | 2 | Polynomial mode select |
| seed_we | input | 1 | Seed write strobe |
| seed_val | input | 32 | Seed value |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Data word can be taken this cycle |
| in_data | input | DATA_W | Data word |
| crc_out | output | 32 | Running checksum, zero-extended |
| chk_go | input | 1 | Compare request |
| chk_expect | input | 32 | Expected checksum |
| chk_done | output | 1 | Compare result valid |
| chk_match | output | 1 | Last compare matched |
| chk_mismatch | output | 1 | Sticky mismatch flag |

## Verification
A word, seed write or mode change presented before a rising edge shows on `crc_out` right after that edge, so the bench drives every input on the falling edge and reads `crc_out` on the next falling edge, one full register stage later. A compare request driven on a falling edge yields `chk_done` and `chk_match` on the following falling edge, and the bench also looks one cycle further to see `chk_done` drop. The expected checksums come from a bench model that walks the data bits in its own way, fed with seeded random modes, seeds, word counts and idle gaps, plus directed cases where a single low bit yields the polynomial itself.

// File: rtl/crc_stream_pkg.sv
package crc_stream_pkg;

  localparam int CRC_MAX_W = 32;

  typedef enum logic [1:0] {
    MODE_ETH32   = 2'd0,
    MODE_CCITT16 = 2'd1,
    MODE_J1850_8 = 2'd2,
    MODE_P2F_8   = 2'd3
  } crc_mode_e;

  function automatic int mode_width(crc_mode_e m);
    case (m)
      MODE_ETH32:   return 32;
      MODE_CCITT16: return 16;
      default:      return 8;
    endcase
  endfunction

  function automatic logic [CRC_MAX_W-1:0] mode_poly(crc_mode_e m);
    case (m)
      MODE_ETH32:   return 32'h04C1_1DB7;
      MODE_CCITT16: return 32'h0000_1021;
      MODE_J1850_8: return 32'h0000_001D;
      default:      return 32'h0000_002F;
    endcase
  endfunction

  function automatic logic [CRC_MAX_W-1:0] width_mask(int w);
    logic [CRC_MAX_W-1:0] m;
    m = '0;
    for (int i = 0; i < CRC_MAX_W; i++)
      if (i < w) m[i] = 1'b1;
    return m;
  endfunction

  // One bit of polynomial division, MSB-first, for a register of width w.
  function automatic logic [CRC_MAX_W-1:0] fold_bit(
    logic [CRC_MAX_W-1:0] c, logic d, logic [CRC_MAX_W-1:0] poly, int w);
    logic fb;
    fb = c[w-1] ^ d;
    c  = (c << 1) & width_mask(w);
    if (fb) c = c ^ poly;
    return c;
  endfunction

endpackage

// File: rtl/crc_lane.sv
module crc_lane
  import crc_stream_pkg::*;
#(
  parameter int                   W      = 32,
  parameter logic [CRC_MAX_W-1:0] POLY   = 32'h04C1_1DB7,
  parameter int                   DATA_W = 32
) (
  input  logic [CRC_MAX_W-1:0] state,
  input  logic [DATA_W-1:0]    word,
  output logic [CRC_MAX_W-1:0] next
);
  localparam logic [CRC_MAX_W-1:0] MASK = width_mask(W);

  always_comb begin
    logic [CRC_MAX_W-1:0] c;
    c = state & MASK;
    for (int i = DATA_W - 1; i >= 0; i--)
      c = fold_bit(c, word[i], POLY, W);
    next = c;
  end
endmodule

// File: rtl/crc_fold_bank.sv
module crc_fold_bank
  import crc_stream_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  crc_mode_e            mode,
  input  logic [CRC_MAX_W-1:0] state,
  input  logic [DATA_W-1:0]    word,
  output logic [CRC_MAX_W-1:0] next
);
  localparam int N_MODES = 4;

  logic [CRC_MAX_W-1:0] lane_out [N_MODES];

  for (genvar g = 0; g < N_MODES; g++) begin : g_lane
    localparam crc_mode_e            LM = crc_mode_e'(g);
    localparam int                   LW = mode_width(LM);
    localparam logic [CRC_MAX_W-1:0] LP = mode_poly(LM);
    crc_lane #(.W(LW), .POLY(LP), .DATA_W(DATA_W)) u_lane (
      .state (state),
      .word  (word),
      .next  (lane_out[g])
    );
  end

  assign next = lane_out[mode];
endmodule

// File: rtl/crc_verify.sv
module crc_verify
  import crc_stream_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic                 reinit,
  input  logic [CRC_MAX_W-1:0] cur,
  input  logic [CRC_MAX_W-1:0] expect_val,
  input  logic [CRC_MAX_W-1:0] mask,
  output logic                 done,
  output logic                 match,
  output logic                 mismatch
);
  logic equal;
  assign equal = ((cur ^ expect_val) & mask) == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      match    <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      done <= go;
      if (go) match <= equal;
      if (reinit)           mismatch <= 1'b0;
      else if (go && !equal) mismatch <= 1'b1;
    end
  end

  // R7: a compare request is answered exactly one cycle later
  assert_done_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> done);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> !done);
  // R8: the mismatch flag only falls on reinitialisation
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch && !reinit |=> mismatch);
  assert_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mismatch) |-> done && !match);
endmodule

// File: rtl/crc_stream_unit.sv
module crc_stream_unit
  import crc_stream_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        poly_sel,
  input  logic              seed_we,
  input  logic [31:0]       seed_val,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic [31:0]       crc_out,
  input  logic              chk_go,
  input  logic [31:0]       chk_expect,
  output logic              chk_done,
  output logic              chk_match,
  output logic              chk_mismatch
);
  crc_mode_e            mode_q;
  crc_mode_e            sel_e;
  logic [CRC_MAX_W-1:0] crc_q;
  logic [CRC_MAX_W-1:0] seed_q;
  logic [CRC_MAX_W-1:0] fold_next;
  logic [CRC_MAX_W-1:0] reinit_mask;
  logic [CRC_MAX_W-1:0] cur_mask;
  logic [CRC_MAX_W-1:0] reload_val;

  // named internal events
  logic sel_change;
  logic reinit;
  logic accept;

  assign sel_e       = crc_mode_e'(poly_sel);
  assign sel_change  = (sel_e != mode_q);
  assign reinit      = seed_we || sel_change;
  assign in_ready    = !reinit;
  assign accept      = in_valid && in_ready;
  assign reinit_mask = width_mask(mode_width(sel_e));
  assign cur_mask    = width_mask(mode_width(mode_q));
  assign reload_val  = (seed_we ? seed_val : seed_q) & reinit_mask;

  crc_fold_bank #(.DATA_W(DATA_W)) u_bank (
    .mode  (mode_q),
    .state (crc_q),
    .word  (in_data),
    .next  (fold_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ETH32;
      crc_q  <= '0;
      seed_q <= '0;
    end else begin
      if (seed_we) seed_q <= seed_val;
      if (reinit) begin
        mode_q <= sel_e;
        crc_q  <= reload_val;
      end else if (accept) begin
        crc_q <= fold_next;
      end
    end
  end

  assign crc_out = crc_q;

  crc_verify u_verify (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (chk_go),
    .reinit     (reinit),
    .cur        (crc_q),
    .expect_val (chk_expect),
    .mask       (cur_mask),
    .done       (chk_done),
    .match      (chk_match),
    .mismatch   (chk_mismatch)
  );

  // R2: a seed write appears on the result, masked to the selected width
  assert_seed_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(seed_we) |-> crc_out == ($past(seed_val) & $past(reinit_mask)));
  // R3: a bare mode change reloads the stored seed
  assert_mode_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_change && !seed_we |=> crc_out == ($past(seed_q) & $past(reinit_mask)));
  // R4: upper result bits are zero in narrow modes
  assert_narrow_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != MODE_ETH32 |-> (crc_out & ~cur_mask) == '0);
  // R6: without an accepted word or reinit the result is stable
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept && !reinit |=> $stable(crc_out));
  // R5: nothing is taken while reinitialising
  assert_no_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |-> !accept);
endmodule

// File: tb/crc_stream_unit_test.sv
module crc_stream_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        poly_sel = 2'd0;
  logic              seed_we = 1'b0;
  logic [31:0]       seed_val = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic [31:0]       crc_out;
  logic              chk_go = 1'b0;
  logic [31:0]       chk_expect = '0;
  logic              chk_done;
  logic              chk_match;
  logic              chk_mismatch;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  // bench model state
  logic [31:0] m_crc  = '0;
  logic [31:0] m_seed = '0;
  logic [1:0]  m_mode = 2'd0;
  logic        m_mism = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_stream_unit #(.DATA_W(DATA_W)) uut (
    .clk, .rst_n, .poly_sel, .seed_we, .seed_val, .in_valid, .in_ready,
    .in_data, .crc_out, .chk_go, .chk_expect, .chk_done, .chk_match,
    .chk_mismatch
  );

  function automatic int ref_w(logic [1:0] m);
    return (m == 2'd0) ? 32 : (m == 2'd1) ? 16 : 8;
  endfunction

  function automatic logic [31:0] ref_mask(logic [1:0] m);
    return (m == 2'd0) ? 32'hFFFF_FFFF : (m == 2'd1) ? 32'h0000_FFFF : 32'h0000_00FF;
  endfunction

  function automatic logic [31:0] ref_poly(logic [1:0] m);
    case (m)
      2'd0: return 32'h04C1_1DB7;
      2'd1: return 32'h0000_1021;
      2'd2: return 32'h0000_001D;
      default: return 32'h0000_002F;
    endcase
  endfunction

  function automatic logic [31:0] ref_fold(logic [31:0] c, logic [DATA_W-1:0] word, logic [1:0] m);
    int w;
    logic top;
    w = ref_w(m);
    for (int k = 0; k < DATA_W; k++) begin
      top = ((c >> (w - 1)) & 32'h1) != 0;
      c = {c[30:0], 1'b0};
      if (top ^ word[DATA_W-1-k]) c = c ^ ref_poly(m);
      c = c & ref_mask(m);
    end
    return c;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_seed(input logic [31:0] s, input logic [1:0] m);
    @(negedge clk);
    seed_we = 1'b1; seed_val = s; poly_sel = m;
    @(negedge clk);
    seed_we = 1'b0;
    m_seed = s; m_mode = m; m_crc = s & ref_mask(m); m_mism = 1'b0;
  endtask

  task automatic push(input logic [DATA_W-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    m_crc = ref_fold(m_crc, d, m_mode);
  endtask

  task automatic compare(input logic [31:0] e, input string req);
    logic exp_match;
    exp_match = ((e ^ m_crc) & ref_mask(m_mode)) == 0;
    @(negedge clk);
    chk_go = 1'b1; chk_expect = e;
    @(negedge clk);
    chk_go = 1'b0;
    if (!exp_match) m_mism = 1'b1;
    check({31'd0, chk_done}, 32'd1, req);
    check({31'd0, chk_match}, {31'd0, exp_match}, req);
    check({31'd0, chk_mismatch}, {31'd0, m_mism}, "R8 sticky flag");
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] hold_v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(crc_out, 32'd0, "R9 crc after reset");
    check({29'd0, chk_done, chk_match, chk_mismatch}, 32'd0, "R9 flags after reset");
    check({31'd0, in_ready}, 32'd1, "R9 ready after reset");

    // R1: a single set low bit on a zero register yields the polynomial
    for (int m = 0; m < 4; m++) begin
      load_seed(32'd0, 2'(m));
      push(32'h0000_0001);
      check(crc_out, ref_poly(2'(m)), "R1 unit word gives polynomial");
      push(32'h8000_0000);
      check(crc_out, m_crc, "R1 second word");
    end

    // R2 / R4: seed masked to width
    load_seed(32'hDEAD_BEEF, 2'd1);
    check(crc_out, 32'h0000_BEEF, "R2 seed masked 16");
    load_seed(32'hDEAD_BEEF, 2'd3);
    check(crc_out, 32'h0000_00EF, "R2 seed masked 8");

    // R5: a word offered during a seed write is dropped
    @(negedge clk);
    seed_we = 1'b1; seed_val = 32'h1234_5678; poly_sel = 2'd0;
    in_valid = 1'b1; in_data = 32'hFFFF_0000;
    #1 check({31'd0, in_ready}, 32'd0, "R5 ready low on seed write");
    @(negedge clk);
    seed_we = 1'b0; in_valid = 1'b0;
    m_seed = 32'h1234_5678; m_mode = 2'd0; m_crc = 32'h1234_5678; m_mism = 1'b0;
    check(crc_out, 32'h1234_5678, "R5 word dropped on seed write");

    // R3 + R5: mode change reloads stored seed, offered word dropped
    push(32'hCAFE_F00D);
    @(negedge clk);
    poly_sel = 2'd2; in_valid = 1'b1; in_data = 32'h0F0F_0F0F;
    @(negedge clk);
    in_valid = 1'b0;
    m_mode = 2'd2; m_crc = m_seed & 32'hFF;
    check(crc_out, 32'h0000_0078, "R3 mode change reload");
    push(32'h0F0F_0F0F);
    check(crc_out, m_crc, "R1 fold in J1850 mode");
    check(crc_out & 32'hFFFF_FF00, 32'd0, "R4 upper bits zero 8-bit");

    // R6: idle cycles hold
    hold_v = crc_out;
    repeat (4) @(negedge clk);
    check(crc_out, hold_v, "R6 hold while idle");

    // R7/R8 directed: good, bad, good, reseed clears
    compare(m_crc, "R7 matching compare");
    @(negedge clk);
    check({31'd0, chk_done}, 32'd0, "R7 done one cycle");
    compare(m_crc ^ 32'h1, "R7 mismatching compare");
    compare(m_crc, "R8 match after mismatch");
    compare(m_crc ^ 32'h100, "R7 bits above width ignored");
    load_seed(32'h0, 2'd2);
    check({31'd0, chk_mismatch}, 32'd0, "R8 cleared by reseed");

    // R10 + random streams
    for (int r = 0; r < 40; r++) begin
      int len;
      load_seed($urandom, 2'($urandom % 4));
      len = 1 + ($urandom % 60);
      if (r == 0) len = 500;
      for (int i = 0; i < len; i++) begin
        if (($urandom % 4) == 0) repeat (1 + $urandom % 3) @(negedge clk);
        push($urandom);
      end
      check(crc_out, m_crc, (r == 0) ? "R10 long stream" : "R1 random stream");
      if (m_mode != 2'd0) check(crc_out & ~ref_mask(m_mode), 32'd0, "R4 narrow upper zero");
      compare(m_crc | (~ref_mask(m_mode) & $urandom), "R7 random verify");
      if (($urandom % 2) == 0) compare(m_crc ^ (1 << ($urandom % ref_w(m_mode))), "R8 random bad verify");
    end

    ended = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule